// File: doc/BRIEF.md
# Rank-Order CFAR Detector

This block is a streaming detector for one line of a range or Doppler profile. It takes one magnitude sample per clock. For every cell it keeps a reference set: `NR` cells on each side of the cell under test, with `NG` guard cells between the reference cells and the test cell. The detection threshold is not the mean of that set. The block picks the k-th smallest reference value and multiplies it by a programmable scale. One or two strong targets inside the reference window therefore do not raise the threshold for a nearby target.

The reference set is held in ascending order by a systolic sorter. Each cell of the sorter stores a magnitude and the sequence tag it arrived with. On every accepted sample, two removal and insertion steps run in cascade. The first step moves one sample out of the far side of the window and one sample in. The second step does the same on the near side. Because every entry is removed by its exact tag, repeated values stay correct. Equal values are ordered oldest first, so the sorted order is always the same for the same input.

A line starts with a sample flagged `in_first`. The rank and the scale are captured at that sample. Each accepted sample produces one output record for the cell `NR+NG` samples earlier. The record is flagged as incomplete until the whole window lies inside the line. The block sustains one cell per clock.

Top module: `oscfar_detector`

## Requirements
- R1: While reset is asserted and after it is released, out_valid, out_full and out_detect are 0, and out_cell and out_thresh are 0.
- R2: Each sample accepted on a rising edge (in_valid high) yields an output record that is visible after that same edge and until the next one. The record refers to the cell D=NR+NG samples earlier in the line. out_valid is 1 only when the accepted sample's line position (0-based, counted from the last accepted in_first) is at least D. out_cell then carries that cell's magnitude.
- R3: out_full is 1 exactly when the line position is at least 2·D. While out_valid is 1 and out_full is 0, both out_detect and out_thresh are 0.
- R4: When out_full is 1, out_thresh = floor(v_k · scale / 2^FRAC). Here v_k is the k-th smallest value (k=1 is the smallest) of the 2·NR reference cells. Those cells sit at line positions pos-2D … pos-D-NG-1 and pos-NR+1 … pos. The test cell and the guard cells never count.
- R5: out_detect is 1 exactly when out_full is 1 and out_cell is strictly greater than out_thresh.
- R6: cfg_rank and cfg_scale are captured only on an accepted in_first sample. Changes to them at any other time have no effect on the thresholds of the current line.
- R7: A captured rank of 0 acts as rank 1. A captured rank above 2·NR acts as rank 2·NR.
- R8: An accepted in_first sample restarts the line at position 0, and no sample of an earlier line ever enters a reference set. in_first while in_valid is low has no effect.
- R9: A cycle with in_valid low changes no window state, and out_valid is 0 after that edge.
- R10: Equal magnitudes are counted individually in the rank selection, so the selected value equals the k-th entry of the reference values sorted with repetition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronous to clk |
| in_valid | input | 1 | A magnitude sample is presented this cycle |
| in_first | input | 1 | The presented sample is the first of a new line |
| in_mag | input | DW | Magnitude sample |
| cfg_rank | input | $clog2(2·NR+1) | Rank k of the order statistic, captured at line start |
| cfg_scale | input | FW | Threshold scale, FRAC fractional bits, captured at line start |
| out_valid | output | 1 | Output record present for one cycle |
| out_full | output | 1 | The record's reference window lies entirely inside the line |
| out_detect | output | 1 | Cell under test exceeds the threshold |
| out_cell | output | DW | Magnitude of the cell under test |
| out_thresh | output | DW+FW | Scaled rank statistic |

## Verification
The assertions take for granted that reset is applied before the first sample and that in_valid, in_first and cfg_rank are never unknown on a clock edge. Under those conditions, the sorter must stay ascending with its invalid entries packed at the top, must be completely valid once a window is full, and must hold the captured rank inside 1…2·NR. The bench drives every input away from the clock edge. Every stream starts with a flagged first sample. Lines are kept far below the reference model's buffer size. The directed cases run rank 0 and over-range ranks through the clamp path, and the random cases use narrow value ranges so that duplicates fill the window.

// File: rtl/oscfar_pkg.sv
package oscfar_pkg;
  localparam int DEF_DW   = 12;
  localparam int DEF_NR   = 4;
  localparam int DEF_NG   = 2;
  localparam int DEF_FW   = 6;
  localparam int DEF_FRAC = 3;
endpackage

// File: rtl/oscfar_sort_step.sv
// One removal/insertion step on an ascending list of tagged entries.
// Entry layout: {valid, value[DW], tag[TW]}; invalid entries sort last.
module oscfar_sort_step #(
  parameter int DW = 12,
  parameter int TW = 5,
  parameter int N  = 8,
  localparam int EW = 1 + DW + TW
) (
  input  logic [N-1:0][EW-1:0] cur,
  input  logic [TW-1:0]        ref_seq,
  input  logic [EW-1:0]        del_e,
  input  logic [EW-1:0]        ins_e,
  output logic [N-1:0][EW-1:0] nxt
);
  // a goes before b: smaller value first, equal values oldest first
  function automatic logic prec(logic [EW-1:0] a, logic [EW-1:0] b, logic [TW-1:0] rs);
    logic [TW-1:0] age_a;
    logic [TW-1:0] age_b;
    age_a = rs - a[TW-1:0];
    age_b = rs - b[TW-1:0];
    if (!a[EW-1]) return 1'b0;
    if (!b[EW-1]) return 1'b1;
    if (a[EW-2:TW] != b[EW-2:TW]) return a[EW-2:TW] < b[EW-2:TW];
    return age_a > age_b;
  endfunction

  logic [N-2:0]          hit;
  logic [N-2:0]          past;
  logic [N-2:0]          lt;
  logic [N-2:0][EW-1:0]  rem;

  always_comb begin
    // removal: exact match on a valid entry, otherwise drop the top slot
    for (int i = 0; i < N-1; i++)
      hit[i] = del_e[EW-1] ? (cur[i] == del_e) : 1'b0;
    past[0] = hit[0];
    for (int i = 1; i < N-1; i++)
      past[i] = past[i-1] | hit[i];
    for (int i = 0; i < N-1; i++)
      rem[i] = past[i] ? cur[i+1] : cur[i];
    // insertion into the N-1 survivors
    for (int i = 0; i < N-1; i++)
      lt[i] = prec(rem[i], ins_e, ref_seq);
    nxt[0] = lt[0] ? rem[0] : ins_e;
    for (int i = 1; i < N-1; i++)
      nxt[i] = lt[i] ? rem[i] : (lt[i-1] ? ins_e : rem[i-1]);
    nxt[N-1] = lt[N-2] ? ins_e : rem[N-2];
  end
endmodule

// File: rtl/oscfar_sorter.sv
// Sorted reference set, two cascaded update steps per accepted sample.
module oscfar_sorter #(
  parameter int DW = 12,
  parameter int TW = 5,
  parameter int N  = 8,
  localparam int EW = 1 + DW + TW
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en,
  input  logic                 clear,
  input  logic [TW-1:0]        ref_seq,
  input  logic [1:0][EW-1:0]   del_e,
  input  logic [1:0][EW-1:0]   ins_e,
  output logic [N-1:0][DW-1:0] s_val,
  output logic [N-1:0]         s_vld
);
  logic [N-1:0][EW-1:0] s_q;
  logic [N-1:0][EW-1:0] s_d;
  logic [N-1:0][EW-1:0] stg [3];

  assign stg[0] = clear ? '0 : s_q;

  for (genvar g = 0; g < 2; g++) begin : g_stage
    oscfar_sort_step #(.DW(DW), .TW(TW), .N(N)) u_step (
      .cur     (stg[g]),
      .ref_seq (ref_seq),
      .del_e   (del_e[g]),
      .ins_e   (ins_e[g]),
      .nxt     (stg[g+1])
    );
  end

  always_comb begin
    s_d = s_q;
    if (en) s_d = stg[2];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) s_q <= '0;
    else        s_q <= s_d;
  end

  always_comb begin
    for (int i = 0; i < N; i++) begin
      s_val[i] = s_q[i][EW-2:TW];
      s_vld[i] = s_q[i][EW-1];
    end
  end

  for (genvar g = 0; g < N-1; g++) begin : g_chk
    assert_sorted_order_R10: assert property (@(posedge clk) disable iff (!rst_n)
      s_q[g+1][EW-1] |-> (s_q[g][EW-1] && (s_q[g][EW-2:TW] <= s_q[g+1][EW-2:TW])));
  end
endmodule

// File: rtl/oscfar_window.sv
// Delay line over the whole window; derives the entries that leave and
// enter both halves of the reference set.
module oscfar_window #(
  parameter int DW = 12,
  parameter int NR = 4,
  parameter int NG = 2,
  parameter int TW = 5,
  parameter int CW = 4,
  localparam int D  = NR + NG,
  localparam int W  = 2 * D + 1,
  localparam int EW = 1 + DW + TW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          acc,
  input  logic          restart,
  input  logic [DW-1:0] in_mag,
  output logic [DW-1:0] cut_val,
  output logic [CW-1:0] cnt_q,
  output logic [TW-1:0] seq_q,
  output logic [EW-1:0] lead_old,
  output logic [EW-1:0] lead_new,
  output logic [EW-1:0] trail_old,
  output logic [EW-1:0] trail_new
);
  logic [W-1:0][EW-1:0] win_q, base, win_d;
  logic [CW-1:0]        cnt_d;
  logic [TW-1:0]        seq_d;

  always_comb begin
    base = win_q;
    if (restart)
      for (int i = 0; i < W; i++) base[i][EW-1] = 1'b0;
    trail_new = {1'b1, in_mag, seq_q};
    trail_old = base[NR-1];
    lead_old  = base[W-1];
    lead_new  = base[W-NR-1];
    win_d = win_q;
    cnt_d = cnt_q;
    seq_d = seq_q;
    if (acc) begin
      win_d = {base[W-2:0], trail_new};
      seq_d = seq_q + TW'(1);
      if (restart)                 cnt_d = CW'(1);
      else if (cnt_q != CW'(W))    cnt_d = cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q <= '0;
      cnt_q <= '0;
      seq_q <= '0;
    end else begin
      win_q <= win_d;
      cnt_q <= cnt_d;
      seq_q <= seq_d;
    end
  end

  assign cut_val = win_q[D][EW-2:TW];

  assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(W));
  assert_hold_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(acc) |-> ($stable(cnt_q) && $stable(seq_q)));
endmodule

// File: rtl/oscfar_detector.sv
module oscfar_detector
  import oscfar_pkg::*;
#(
  parameter int DW   = DEF_DW,
  parameter int NR   = DEF_NR,
  parameter int NG   = DEF_NG,
  parameter int FW   = DEF_FW,
  parameter int FRAC = DEF_FRAC,
  localparam int D    = NR + NG,
  localparam int W    = 2 * D + 1,
  localparam int NREF = 2 * NR,
  localparam int TW   = $clog2(W) + 1,
  localparam int CW   = $clog2(W + 1),
  localparam int KW   = $clog2(NREF + 1),
  localparam int THW  = DW + FW,
  localparam int EW   = 1 + DW + TW
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  input  logic           in_first,
  input  logic [DW-1:0]  in_mag,
  input  logic [KW-1:0]  cfg_rank,
  input  logic [FW-1:0]  cfg_scale,
  output logic           out_valid,
  output logic           out_full,
  output logic           out_detect,
  output logic [DW-1:0]  out_cell,
  output logic [THW-1:0] out_thresh
);
  logic restart;
  logic acc_q, acc_d;
  logic [KW-1:0] rank_q, rank_d;
  logic [FW-1:0] scale_q, scale_d;
  logic [DW-1:0] cut_val;
  logic [CW-1:0] cnt_q;
  logic [TW-1:0] seq_q;
  logic [EW-1:0] lead_old, lead_new, trail_old, trail_new;
  logic [NREF-1:0][DW-1:0] s_val;
  logic [NREF-1:0]         s_vld;
  logic [DW-1:0]  stat;
  logic [THW-1:0] prod, thr;
  logic           full_w;

  assign restart = in_valid & in_first;

  oscfar_window #(.DW(DW), .NR(NR), .NG(NG), .TW(TW), .CW(CW)) u_win (
    .clk, .rst_n, .acc(in_valid), .restart, .in_mag,
    .cut_val, .cnt_q, .seq_q,
    .lead_old, .lead_new, .trail_old, .trail_new
  );

  oscfar_sorter #(.DW(DW), .TW(TW), .N(NREF)) u_sort (
    .clk, .rst_n, .en(in_valid), .clear(restart), .ref_seq(seq_q),
    .del_e({trail_old, lead_old}),
    .ins_e({trail_new, lead_new}),
    .s_val, .s_vld
  );

  // next state: rank and scale captured at line start, rank clamped
  always_comb begin
    acc_d   = in_valid;
    rank_d  = rank_q;
    scale_d = scale_q;
    if (restart) begin
      scale_d = cfg_scale;
      if (cfg_rank == '0)               rank_d = KW'(1);
      else if (cfg_rank > KW'(NREF))    rank_d = KW'(NREF);
      else                              rank_d = cfg_rank;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q   <= 1'b0;
      rank_q  <= KW'(1);
      scale_q <= '0;
    end else begin
      acc_q   <= acc_d;
      rank_q  <= rank_d;
      scale_q <= scale_d;
    end
  end

  always_comb begin
    stat = '0;
    for (int i = 0; i < NREF; i++)
      if (rank_q == KW'(i + 1)) stat = s_val[i];
    prod   = THW'(stat) * THW'(scale_q);
    thr    = prod >> FRAC;
    full_w = (cnt_q == CW'(W));
    out_valid  = acc_q && (cnt_q > CW'(D));
    out_full   = out_valid && full_w;
    out_cell   = out_valid ? cut_val : '0;
    out_thresh = out_full ? thr : '0;
    out_detect = out_full && (THW'(cut_val) > thr);
  end

  assert_full_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == CW'(W)) |-> (&s_vld));
  assert_rank_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rank_q >= KW'(1)) && (rank_q <= KW'(NREF)));
  assert_rank_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(in_valid && in_first) |-> ($stable(rank_q) && $stable(scale_q)));
  assert_detect_full_R5: assert property (@(posedge clk) disable iff (!rst_n)
    out_detect |-> out_full);
  assert_valid_after_accept_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid));
endmodule

// File: tb/sim_oscfar_detector.sv
module sim_oscfar_detector;
  localparam int DW = 12, NR = 4, NG = 2, FW = 6, FRAC = 3;
  localparam int D = NR + NG, NREF = 2 * NR, KW = $clog2(NREF + 1), THW = DW + FW;

  logic clk = 1'b0;
  logic rst_n;
  logic in_valid, in_first;
  logic [DW-1:0] in_mag;
  logic [KW-1:0] cfg_rank;
  logic [FW-1:0] cfg_scale;
  logic out_valid, out_full, out_detect;
  logic [DW-1:0] out_cell;
  logic [THW-1:0] out_thresh;

  always #4 clk = ~clk;  // 8 time units per cycle: 125 MHz

  oscfar_detector u0 (.*);

  int checks = 0, failures = 0;
  bit done = 0;
  int line_buf [0:1023];
  int lpos = 0, b_rank = 1, b_scale = 0;
  bit has_exp = 0;
  int e_valid, e_full, e_det, e_cell, e_thr;
  string e_vtag, e_ttag;

  task automatic chk(string r, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", r, act, exp);
    end
  endtask

  function automatic int kth(int p, int k);
    int r[NREF];
    int n = 0;
    int t;
    for (int j = p - 2*D; j <= p - D - NG - 1; j++) begin r[n] = line_buf[j]; n++; end
    for (int j = p - D + NG + 1; j <= p; j++) begin r[n] = line_buf[j]; n++; end
    for (int a = 0; a < NREF; a++)
      for (int b = 0; b < NREF - 1 - a; b++)
        if (r[b] > r[b+1]) begin t = r[b]; r[b] = r[b+1]; r[b+1] = t; end
    return r[k-1];
  endfunction

  task automatic check_prev();
    if (has_exp) begin
      chk(e_vtag, int'(out_valid), e_valid);
      if (e_valid != 0) begin
        chk("R2 cell", int'(out_cell), e_cell);
        chk("R3 full", int'(out_full), e_full);
        chk(e_ttag, int'(out_thresh), e_thr);
        chk("R5 detect", int'(out_detect), e_det);
      end
    end
  endtask

  task automatic step(bit v, bit f, int mag, int rk, int sc, string tag);
    int p;
    check_prev();
    in_valid = v; in_first = f; in_mag = DW'(mag);
    cfg_rank = KW'(rk); cfg_scale = FW'(sc);
    if (v) begin
      if (f) begin
        lpos = 0;
        b_rank = (rk == 0) ? 1 : ((rk > NREF) ? NREF : rk);
        b_scale = sc;
      end
      line_buf[lpos] = mag;
      p = lpos;
      if (lpos < 1023) lpos++;
      e_valid = (p >= D) ? 1 : 0;
      e_full  = (p >= 2*D) ? 1 : 0;
      e_cell  = e_valid ? line_buf[p-D] : 0;
      if (e_full != 0) begin
        e_thr = (kth(p, b_rank) * b_scale) >> FRAC;
        e_det = (e_cell > e_thr) ? 1 : 0;
      end else begin
        e_thr = 0; e_det = 0;
      end
      e_vtag = "R2 valid";
    end else begin
      e_valid = 0;
      e_vtag = "R9 idle";
    end
    e_ttag = {tag, " thresh"};
    has_exp = 1;
    @(negedge clk);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      failures++;
      $display("FAIL R2 watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int seed;
    int len, rk, sc, maxv;
    seed = $urandom(32'h5eed);
    rst_n = 1'b0; in_valid = 0; in_first = 0; in_mag = '0; cfg_rank = '0; cfg_scale = '0;
    repeat (3) @(negedge clk);
    // R1: outputs quiet in reset
    chk("R1 valid", int'(out_valid), 0);
    chk("R1 full", int'(out_full), 0);
    chk("R1 detect", int'(out_detect), 0);
    chk("R1 thresh", int'(out_thresh), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 cell", int'(out_cell), 0);

    // R10/R5: flat line of duplicates, one cell just above the level
    for (int i = 0; i < 30; i++)
      step(1, i == 0, (i == 20) ? 101 : 100, 5, 8, "R10");
    // R7: rank 0 and over-range rank
    for (int i = 0; i < 24; i++) step(1, i == 0, $urandom_range(0, 4095), 0, 8, "R7");
    for (int i = 0; i < 24; i++) step(1, i == 0, $urandom_range(0, 4095), 15, 9, "R7");
    // R6: rank and scale move every cycle mid-line
    for (int i = 0; i < 30; i++)
      step(1, i == 0, $urandom_range(0, 255), (i == 0) ? 3 : $urandom_range(0, 15),
           (i == 0) ? 12 : $urandom_range(0, 63), "R6");
    // R8: large line, then new line of small values; in_first with in_valid low
    for (int i = 0; i < 20; i++) step(1, i == 0, 4000, 8, 8, "R8");
    step(0, 1, 0, 1, 1, "R8");
    for (int i = 0; i < 20; i++) step(1, i == 0, 10 + i, 8, 8, "R8");
    // R9: gaps inside a line
    for (int i = 0; i < 40; i++) begin
      step(1, i == 0, $urandom_range(0, 63), 4, 16, "R9");
      if (i % 3 == 1) step(0, 0, 0, 4, 16, "R9");
    end
    // random lines, narrow value ranges give heavy duplication
    for (int l = 0; l < 60; l++) begin
      len  = $urandom_range(5, 90);
      rk   = $urandom_range(0, 15);
      sc   = $urandom_range(0, 63);
      maxv = (l % 2 == 0) ? 7 : 4095;
      for (int i = 0; i < len; i++) begin
        if ($urandom_range(0, 9) < 2) step(0, $urandom_range(0, 1), 0, 0, 0, "R4");
        step(1, i == 0, $urandom_range(0, maxv), (i == 0) ? rk : $urandom_range(0, 15),
             (i == 0) ? sc : $urandom_range(0, 63), (l % 2 == 0) ? "R10" : "R4");
      end
    end
    step(0, 0, 0, 0, 0, "R9");
    check_prev();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule